// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level and Idle-Data Interrupt

This block is the receive-side byte store of a serial channel. A deserializer pushes each completed character through a write strobe, and the host pops characters through a read strobe. The storage depth is either 8 or 16 bytes. The depth select is sampled only when the queue is reset or flushed, so a depth change never disturbs data already stored.

An interrupt request is raised when the number of held bytes reaches a level that two control bits choose. The mapping from code to level is not linear, and it differs between the two depths. An idle-data timer adds a second interrupt source. It counts 1X bit-time ticks while bytes sit in the queue with no host or deserializer activity. After 64 such ticks it latches a flag, so that a short tail of a message that never reaches the fill level still gets serviced.

Top module: `rxq_watch`

## Requirements
- R1: After reset, fill is 0 and ready, full, overrun, irq and rd_data are all 0.
- R2: The capacity is 8 when deep_sel was 0 at the last reset or flush, and 16 when it was 1. A change of deep_sel at any other time has no effect. ready means fill is not 0, and full means fill equals the capacity.
- R3: Bytes leave in the order they were written. A read strobe with data present places the oldest byte on rd_data in the cycle after the strobe. rd_data then holds that byte until the next accepted read.
- R4: A write strobe while full is dropped and leaves fill unchanged. It sets overrun, which stays set until a flush or reset.
- R5: A read strobe while empty leaves fill unchanged and keeps rd_data at the last byte read.
- R6: With capacity 8, the level code {lvl_hi, lvl_lo} of 00, 01, 10 and 11 raises irq when fill is at least 1, 6, 4 and 8 respectively.
- R7: With capacity 16, the codes 00, 01, 10 and 11 raise irq when fill is at least 1, 8, 12 and 16 respectively.
- R8: With wd_en high and data held, the 64th bit_tick with no wr_en or rd_en strobe since the last strobe or flush sets the idle flag. irq is high from the following cycle.
- R9: Any wr_en or rd_en strobe, accepted or not, clears the idle flag and restarts the tick count.
- R10: While wd_en is low, the idle flag stays clear and the count stays at zero.
- R11: A flush empties the queue, clears overrun and the idle timer, and loads the depth from deep_sel. Read data is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous queue reset; loads the depth mode |
| deep_sel | input | 1 | 0 selects 8 entries, 1 selects 16 |
| lvl_hi | input | 1 | Upper bit of the level code |
| lvl_lo | input | 1 | Lower bit of the level code |
| wd_en | input | 1 | Idle-data timer enable |
| bit_tick | input | 1 | One-cycle pulse per 1X bit time |
| wr_en | input | 1 | Deserializer write strobe |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Last byte read |
| fill | output | 5 | Number of bytes held |
| ready | output | 1 | At least one byte held |
| full | output | 1 | Queue at capacity |
| overrun | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Level hit OR idle flag |

## Verification
The bench goes after the non-linear level table in both depths. A design that used the same table for both depths, or swapped codes 01 and 10, would report irq at the wrong fill. It drives writes into a full queue and reads from an empty one; pointers that moved there would corrupt the byte order or fill. It changes deep_sel without a flush, which a design sampling it live would use to grow past 8 entries. It steps the idle timer to exactly 63 and 64 ticks, with a strobe in between, which catches an off-by-one count or a strobe that fails to restart it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Fill level that raises the request, derived from the active capacity.
  // Deep mode: 1, cap/2, 3cap/4, cap. Shallow mode: 1, 3cap/4, cap/2, cap.
  function automatic int fill_goal(input logic deep, input logic [1:0] code, input int cap);
    int quarter3;
    int half;
    quarter3 = cap - cap / 4;
    half     = cap / 2;
    case (code)
      2'b00:   fill_goal = 1;
      2'b01:   fill_goal = deep ? half : quarter3;
      2'b10:   fill_goal = deep ? quarter3 : half;
      default: fill_goal = cap;
    endcase
  endfunction

  // Circular pointer advance with wrap at the active capacity.
  function automatic int ptr_next(input int ptr, input int cap);
    ptr_next = (ptr == cap - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW        = 8,
  parameter int DEEP_N    = 16,
  parameter int SHALLOW_N = 8,
  localparam int PW = $clog2(DEEP_N),
  localparam int CW = $clog2(DEEP_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          deep_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill,
  output logic          ready,
  output logic          full,
  output logic          overrun,
  output logic          deep_act,
  output logic          wr_take,
  output logic          rd_take
);

  logic [DW-1:0] mem [DEEP_N];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          wr_drop;

  assign cap     = deep_act ? CW'(DEEP_N) : CW'(SHALLOW_N);
  assign ready   = (fill != '0);
  assign full    = (fill == cap);
  assign wr_take = wr_en && !full && !flush;
  assign rd_take = rd_en && ready && !flush;
  assign wr_drop = wr_en && full && !flush;

  always_ff @(posedge clk) begin
    if (wr_take) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      overrun  <= 1'b0;
      deep_act <= deep_sel;
      rd_data  <= '0;
    end else if (flush) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      overrun  <= 1'b0;
      deep_act <= deep_sel;
    end else begin
      if (wr_take) wptr <= PW'(rxq_pkg::ptr_next(int'(wptr), int'(cap)));
      if (rd_take) begin
        rptr    <= PW'(rxq_pkg::ptr_next(int'(rptr), int'(cap)));
        rd_data <= mem[rptr];
      end
      case ({wr_take, rd_take})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (wr_drop) overrun <= 1'b1;
    end
  end

  p_fill_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= cap);
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> $stable(fill));
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && rd_en && !wr_en && !flush) |=> ($stable(rd_data) && fill == '0));

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEEP_N    = 16,
  parameter int SHALLOW_N = 8,
  localparam int CW = $clog2(DEEP_N + 1)
) (
  input  logic          deep_act,
  input  logic [1:0]    code,
  input  logic [CW-1:0] fill,
  output logic          lvl_hit
);

  logic [CW-1:0] goal;

  assign goal    = CW'(rxq_pkg::fill_goal(deep_act, code, deep_act ? DEEP_N : SHALLOW_N));
  assign lvl_hit = (fill >= goal);

  always_comb begin
    a_goal_nonzero_r6: assert (goal != '0);
  end

endmodule

// File: rtl/rxq_wdog.sv
module rxq_wdog #(
  parameter int WD_LIMIT = 64,
  localparam int TW = $clog2(WD_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic enable,
  input  logic access,
  input  logic tick,
  input  logic holding,
  output logic wd_flag
);

  logic [TW-1:0] cnt;
  logic          last_tick;

  assign last_tick = tick && (cnt == TW'(WD_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      wd_flag <= 1'b0;
    end else if (flush || !enable || access) begin
      cnt     <= '0;
      wd_flag <= 1'b0;
    end else if (!holding) begin
      cnt     <= '0;
    end else if (tick && cnt != TW'(WD_LIMIT)) begin
      cnt <= cnt + 1'b1;
      if (last_tick) wd_flag <= 1'b1;
    end
  end

  p_wd_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TW'(WD_LIMIT));
  p_wd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> (!wd_flag && cnt == '0));
  p_wd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!wd_flag && cnt == '0));

endmodule

// File: rtl/rxq_watch.sv
module rxq_watch #(
  parameter int DW        = 8,
  parameter int DEEP_N    = 16,
  parameter int SHALLOW_N = 8,
  parameter int WD_LIMIT  = 64,
  localparam int CW = $clog2(DEEP_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          deep_sel,
  input  logic          lvl_hi,
  input  logic          lvl_lo,
  input  logic          wd_en,
  input  logic          bit_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill,
  output logic          ready,
  output logic          full,
  output logic          overrun,
  output logic          irq
);

  logic       deep_act;
  logic       wr_take, rd_take;
  logic       lvl_hit;
  logic       wd_flag;
  logic       access;
  logic [1:0] code;

  assign code   = {lvl_hi, lvl_lo};
  assign access = wr_en || rd_en;

  rxq_store #(.DW(DW), .DEEP_N(DEEP_N), .SHALLOW_N(SHALLOW_N)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .deep_sel(deep_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .fill(fill), .ready(ready), .full(full), .overrun(overrun),
    .deep_act(deep_act), .wr_take(wr_take), .rd_take(rd_take)
  );

  rxq_level #(.DEEP_N(DEEP_N), .SHALLOW_N(SHALLOW_N)) u_level (
    .deep_act(deep_act), .code(code), .fill(fill), .lvl_hit(lvl_hit)
  );

  rxq_wdog #(.WD_LIMIT(WD_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .flush(flush), .enable(wd_en),
    .access(access), .tick(bit_tick), .holding(ready), .wd_flag(wd_flag)
  );

  assign irq = lvl_hit || wd_flag;

  p_code0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && code == 2'b00) |-> irq);
  p_full_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> irq);
  p_wd_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_flag |-> ready);
  p_take_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(wr_take || rd_take));
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0 && !overrun && !irq));

endmodule

// File: tb/tb_rxq_watch.sv
module tb_rxq_watch;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, deep_sel = 1'b0, lvl_hi = 1'b0, lvl_lo = 1'b0;
  logic       wd_en = 1'b0, bit_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] fill;
  logic       ready, full, overrun, irq;

  int checks = 0;
  int bad = 0;

  // reference state
  logic [7:0] mq [16];
  int  mcnt = 0, mcap = 8, mwcnt = 0;
  bit  mdeep = 0, movr = 0, mwflag = 0;
  logic [7:0] mlast = '0;

  always #(PERIOD/2) clk = ~clk;

  rxq_watch dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .deep_sel(deep_sel),
    .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .wd_en(wd_en), .bit_tick(bit_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .fill(fill), .ready(ready), .full(full), .overrun(overrun), .irq(irq)
  );

  function automatic int exp_thr(bit deep, bit [1:0] code);
    if (!deep) begin
      case (code) 2'b00: return 1; 2'b01: return 6; 2'b10: return 4; default: return 8; endcase
    end else begin
      case (code) 2'b00: return 1; 2'b01: return 8; 2'b10: return 12; default: return 16; endcase
    end
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit eirq;
    string itag;
    eirq = (mcnt >= exp_thr(mdeep, {lvl_hi, lvl_lo})) || mwflag;
    itag = mwflag ? "R8" : (mdeep ? "R7" : "R6");
    chk("R2", int'(fill), mcnt, "fill");
    chk("R2", int'(ready), int'(mcnt > 0), "ready");
    chk("R2", int'(full), int'(mcnt == mcap), "full");
    chk("R3", int'(rd_data), int'(mlast), "rd_data");
    chk("R4", int'(overrun), int'(movr), "overrun");
    chk(itag, int'(irq), int'(eirq), "irq");
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit w, logic [7:0] d, bit r, bit t, bit fl);
    bit wok, rok;
    wr_en = w; wr_data = d; rd_en = r; bit_tick = t; flush = fl;
    @(posedge clk);
    if (fl || !wd_en || w || r) begin mwcnt = 0; mwflag = 0; end
    else if (mcnt == 0) mwcnt = 0;
    else if (t && mwcnt < 64) begin mwcnt++; if (mwcnt == 64) mwflag = 1; end
    if (fl) begin
      mcnt = 0; movr = 0; mdeep = deep_sel; mcap = deep_sel ? 16 : 8;
    end else begin
      wok = w && (mcnt < mcap);
      rok = r && (mcnt > 0);
      if (rok) begin
        mlast = mq[0];
        for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (wok) begin mq[mcnt] = d; mcnt++; end
      if (w && !wok) movr = 1;
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; bit_tick = 0; flush = 0;
    compare_all();
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL timeout all requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(fill), 0, "fill");
    chk("R1", int'(ready | full | overrun | irq), 0, "flags");
    chk("R1", int'(rd_data), 0, "rd_data");

    // R6: shallow thresholds, fill one byte at a time per code
    for (int c = 0; c < 4; c++) begin
      {lvl_hi, lvl_lo} = 2'(c);
      cyc(0, 0, 0, 0, 1);
      for (int k = 1; k <= 8; k++) begin
        cyc(1, 8'(k * 17 + c), 0, 0, 0);
        chk("R6", int'(irq), int'(k >= exp_thr(0, 2'(c))), "shallow irq");
      end
    end
    // R4: write while full dropped, overrun sticky
    cyc(1, 8'hEE, 0, 0, 0);
    chk("R4", int'(fill), 8, "fill after drop");
    chk("R4", int'(overrun), 1, "overrun set");
    // R2: deep_sel change without flush has no effect
    deep_sel = 1;
    cyc(1, 8'hEF, 0, 0, 0);
    chk("R2", int'(fill), 8, "depth unchanged without flush");
    // R3: order of drain
    for (int k = 1; k <= 8; k++) begin
      cyc(0, 0, 1, 0, 0);
      chk("R3", int'(rd_data), (k * 17 + 3) & 255, "drain order");
    end
    // R5: read while empty
    cyc(0, 0, 1, 0, 0);
    chk("R5", int'(rd_data), (8 * 17 + 3) & 255, "empty read data");
    chk("R5", int'(fill), 0, "empty read fill");
    chk("R4", int'(overrun), 1, "overrun still set");
    // R11 flush loads deep mode, clears overrun
    cyc(0, 0, 0, 0, 1);
    chk("R11", int'(overrun), 0, "overrun cleared");
    chk("R11", int'(rd_data), (8 * 17 + 3) & 255, "rd_data kept");
    // R7: deep thresholds
    for (int c = 0; c < 4; c++) begin
      {lvl_hi, lvl_lo} = 2'(c);
      cyc(0, 0, 0, 0, 1);
      for (int k = 1; k <= 16; k++) begin
        cyc(1, 8'(k), 0, 0, 0);
        chk("R7", int'(irq), int'(k >= exp_thr(1, 2'(c))), "deep irq");
      end
      chk("R2", int'(full), 1, "full at 16");
    end

    // R8 idle timer
    {lvl_hi, lvl_lo} = 2'b11;
    wd_en = 1;
    cyc(0, 0, 0, 0, 1);
    cyc(1, 8'h5A, 0, 0, 0);
    repeat (63) cyc(0, 0, 0, 1, 0);
    chk("R8", int'(irq), 0, "irq after 63 ticks");
    cyc(0, 0, 0, 1, 0);
    chk("R8", int'(irq), 1, "irq after 64 ticks");
    // R9 strobe clears and restarts
    cyc(1, 8'h5B, 0, 0, 0);
    chk("R9", int'(irq), 0, "flag cleared by write");
    repeat (63) cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 0);
    repeat (63) cyc(0, 0, 0, 1, 0);
    chk("R9", int'(irq), 0, "restart after read");
    cyc(0, 0, 0, 1, 0);
    chk("R9", int'(irq), 1, "fires after restart");
    // R10 disabled
    wd_en = 0;
    repeat (70) cyc(0, 0, 0, 1, 0);
    chk("R10", int'(irq), 0, "disabled timer");
    // empty queue never fires
    wd_en = 1;
    cyc(0, 0, 0, 0, 1);
    repeat (70) cyc(0, 0, 0, 1, 0);
    chk("R8", int'(irq), 0, "empty queue no idle irq");

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      bit w, r, t, fl;
      w  = ($urandom_range(99) < 50);
      r  = ($urandom_range(99) < 42);
      t  = ($urandom_range(99) < 60);
      fl = ($urandom_range(999) < 8);
      if ($urandom_range(99) < 3) {lvl_hi, lvl_lo} = 2'($urandom_range(3));
      if ($urandom_range(99) < 2) deep_sel = ~deep_sel;
      if ($urandom_range(199) < 2) wd_en = ~wd_en;
      if (n % 500 < 200) begin r = 0; w = 0; end
      cyc(w, 8'($urandom), r, t, fl);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule